// File: doc/BRIEF.md
# Configuration Register File with Command Register

This block holds a byte-wide configuration memory of 256 locations that a slave-side front end (for example an SMBus slave engine) reads and writes through a parallel address / data / write-strobe port. The 255 lower locations store plain configuration bytes. The top location is a command register with three live bits. One bit reloads the whole memory with its default contents. One bit requests an attach event and write-protects the lower locations. One bit asks for the slave interface to power down once the acknowledge in progress has finished.

Downstream logic reads the stored configuration through a second, independent read port. The attach request and the interface power-down flag are plain outputs. Each lower location has a default equal to its address XORed with a parameter constant (`DEF_XOR`, default A5h). A hardware reset and a command-driven reload both restore that default.

Top module: `cfgmem_regfile`

## Requirements
- R1: While `rst_n` is low and after it is released, every location 00h–FEh holds `addr ^ DEF_XOR`. Address FFh reads 00h. `attach_req` and `intf_pwrdn` are 0.
- R2: When the block is not write-protected, a write with `wr_en` high to an address in 00h–FEh is stored at the clock edge. `rd_data` shows the byte at `addr` and `tap_data` shows the byte at `tap_addr`, combinationally.
- R3: Address FFh reads as {5'b0, bit2 power-down request, bit1 reload, bit0 attach}. Bits 7:3 always read 0, and writing them has no effect.
- R4: Writing FFh with bit1 set makes FFh bit1 read 1 for exactly one cycle. At the end of that cycle every location 00h–FEh returns to its default, all command bits clear, and any write presented during that cycle is dropped.
- R5: Writing FFh with bit0 set drives `attach_req` high from the next cycle. While it is set, writes to 00h–FEh are dropped and reads still return the stored bytes. Writing bit0 as 0 releases the protection.
- R6: `intf_pwrdn` rises at the first clock edge where `ack_done` is 1 and the stored bit2 is 1. An `ack_done` in the same cycle as the write that sets bit2 does not count. `ack_done` with bit2 clear has no effect.
- R7: Once high, `intf_pwrdn` stays high through a clear of bit2 and through a command reload. Only `rst_n` clears it.
- R8: Address FFh stays writable while the attach bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for `addr` / `wr_data` |
| addr | input | 8 | Slave-port address |
| wr_data | input | 8 | Slave-port write byte |
| rd_data | output | 8 | Slave-port read byte at `addr` |
| ack_done | input | 1 | Pulse: current acknowledge has completed |
| tap_addr | input | 8 | Downstream read address |
| tap_data | output | 8 | Downstream read byte at `tap_addr` |
| attach_req | output | 1 | Attach event requested (bit0 of FFh) |
| intf_pwrdn | output | 1 | Slave interface powered down (sticky) |

## Verification
A stuck or lost reload bit shows up on the cycle after the reload write. FFh then reads with bit1 still set, or the written location keeps its data where its default is expected. A protection fault shows on the first read after a dropped write, because the new byte appears instead of the old one. A power-down flag that is armed too early or cleared wrongly shows at `intf_pwrdn` one edge after the `ack_done` pulse, or after the following command write.

// File: rtl/cfgmem_pkg.sv
// cfgmem_pkg: shared command-register layout for the configuration memory.
// Assumes the command register occupies the three low data bits.
package cfgmem_pkg;
    localparam int CMD_ATTACH_BIT = 0;
    localparam int CMD_RELOAD_BIT = 1;
    localparam int CMD_PWRDN_BIT  = 2;
    localparam int CMD_LIVE_BITS  = 3;

    typedef struct packed {
        logic pwrdn;     // bit 2
        logic reload;    // bit 1
        logic attach;    // bit 0
    } cmd_t;
endpackage

// File: rtl/cfgmem_word.sv
// cfgmem_word: one configuration byte with a fixed default value.
// Assumes reload has priority over a write in the same cycle.
module cfgmem_word #(
    parameter int               DATA_W  = 8,
    parameter logic [DATA_W-1:0] DEFAULT = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reload,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] q
);
    // Hold the byte: default on reset or reload, else take the write.
    always_ff @(posedge clk) begin
        if (!rst_n || reload) begin
            q <= DEFAULT;
        end else if (we) begin
            q <= wdata;
        end
    end
endmodule

// File: rtl/cfgmem_array.sv
// cfgmem_array: storage for the lower DEPTH-1 locations, two read ports.
// Each location's default is its address XORed with DEF_XOR. A read of
// the top address returns zero here, and the parent overlays the command
// register there.
module cfgmem_array #(
    parameter int               ADDR_W  = 8,
    parameter int               DATA_W  = 8,
    parameter logic [DATA_W-1:0] DEF_XOR = 8'hA5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reload,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr_a,
    output logic [DATA_W-1:0] rdata_a,
    input  logic [ADDR_W-1:0] raddr_b,
    output logic [DATA_W-1:0] rdata_b
);
    localparam int DEPTH  = 1 << ADDR_W;
    localparam int STORED = DEPTH - 1;

    logic [DATA_W-1:0] words [STORED];

    for (genvar i = 0; i < STORED; i++) begin : g_word
        localparam logic [DATA_W-1:0] DFLT = DATA_W'(i) ^ DEF_XOR;
        logic sel_we;
        // Address decode for this location.
        assign sel_we = we && (waddr == ADDR_W'(i));
        cfgmem_word #(.DATA_W(DATA_W), .DEFAULT(DFLT)) u_word (
            .clk   (clk),
            .rst_n (rst_n),
            .reload(reload),
            .we    (sel_we),
            .wdata (wdata),
            .q     (words[i])
        );
    end

    // Slave-side read mux.
    always_comb begin
        rdata_a = '0;
        if (raddr_a != ADDR_W'(STORED)) rdata_a = words[raddr_a];
    end

    // Downstream read mux.
    always_comb begin
        rdata_b = '0;
        if (raddr_b != ADDR_W'(STORED)) rdata_b = words[raddr_b];
    end
endmodule

// File: rtl/cfgmem_cmd.sv
// cfgmem_cmd: command register and sticky interface power-down flag.
// Assumes the reload bit clears the whole register one cycle after it is
// set, and that command writes during that cycle are dropped.
module cfgmem_cmd
    import cfgmem_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_we,
    input  cmd_t cmd_wdata,
    input  logic ack_done,
    output cmd_t cmd_q,
    output logic pwrdn_flag
);
    // Command register: clear on reset or reload, else load on write.
    always_ff @(posedge clk) begin
        if (!rst_n || cmd_q.reload) begin
            cmd_q <= '0;
        end else if (cmd_we) begin
            cmd_q <= cmd_wdata;
        end
    end

    // Power-down flag: armed by stored bit2, fired by ack_done, sticky.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pwrdn_flag <= 1'b0;
        end else if (cmd_q.pwrdn && ack_done) begin
            pwrdn_flag <= 1'b1;
        end
    end
endmodule

// File: rtl/cfgmem_regfile.sv
// cfgmem_regfile: configuration memory with a command register at the top
// address. It decodes slave writes into the storage array and the command
// register, applies write protection, and overlays the command register
// on reads of the top address. Assumes a synchronous active-low reset.
module cfgmem_regfile
    import cfgmem_pkg::*;
#(
    parameter int               ADDR_W  = 8,
    parameter int               DATA_W  = 8,
    parameter logic [DATA_W-1:0] DEF_XOR = 8'hA5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    input  logic              ack_done,
    input  logic [ADDR_W-1:0] tap_addr,
    output logic [DATA_W-1:0] tap_data,
    output logic              attach_req,
    output logic              intf_pwrdn
);
    localparam logic [ADDR_W-1:0] CMD_ADDR = {ADDR_W{1'b1}};

    cmd_t              cmd_q;
    cmd_t              cmd_wdata;
    logic              cmd_hit;
    logic              cmd_we;
    logic              mem_we;
    logic [DATA_W-1:0] mem_rdata;
    logic [DATA_W-1:0] tap_rdata;
    logic              unused_rsvd;

    // Write decode: the command register is always writable, the array is
    // writable only while unprotected and not reloading.
    always_comb begin
        cmd_hit   = (addr == CMD_ADDR);
        cmd_we    = wr_en && cmd_hit;
        mem_we    = wr_en && !cmd_hit && !cmd_q.attach && !cmd_q.reload;
        cmd_wdata = cmd_t'(wr_data[CMD_LIVE_BITS-1:0]);
    end

    // Reserved write bits are discarded.
    assign unused_rsvd = ^wr_data[DATA_W-1:CMD_LIVE_BITS];

    cfgmem_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEF_XOR(DEF_XOR)) u_array (
        .clk    (clk),
        .rst_n  (rst_n),
        .reload (cmd_q.reload),
        .we     (mem_we),
        .waddr  (addr),
        .wdata  (wr_data),
        .raddr_a(addr),
        .rdata_a(mem_rdata),
        .raddr_b(tap_addr),
        .rdata_b(tap_rdata)
    );

    cfgmem_cmd u_cmd (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_we    (cmd_we),
        .cmd_wdata (cmd_wdata),
        .ack_done  (ack_done),
        .cmd_q     (cmd_q),
        .pwrdn_flag(intf_pwrdn)
    );

    // Read overlay: the top address returns the command register.
    always_comb begin
        rd_data = cmd_hit ? {{(DATA_W-CMD_LIVE_BITS){1'b0}}, cmd_q} : mem_rdata;
    end

    // Downstream port sees the array only.
    assign tap_data   = tap_rdata;
    assign attach_req = cmd_q.attach;
endmodule

// File: rtl/cfgmem_regfile_chk.sv
// cfgmem_regfile_chk: property checker bound to cfgmem_regfile.
module cfgmem_regfile_chk #(
    parameter int               ADDR_W  = 8,
    parameter int               DATA_W  = 8,
    parameter logic [DATA_W-1:0] DEF_XOR = 8'hA5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] rd_data,
    input logic              ack_done,
    input logic [ADDR_W-1:0] tap_addr,
    input logic [DATA_W-1:0] tap_data,
    input logic              attach_req,
    input logic              intf_pwrdn,
    input logic              reload_bit,
    input logic              pwrdn_bit
);
    localparam logic [ADDR_W-1:0] CMD_ADDR = {ADDR_W{1'b1}};

    p_rsvd_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == CMD_ADDR) |-> (rd_data[DATA_W-1:3] == '0));

    p_reload_once_r4: assert property (@(posedge clk) disable iff (!rst_n)
        reload_bit |=> !reload_bit);

    p_reload_dflt_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(reload_bit) && tap_addr != CMD_ADDR)
        |-> (tap_data == (DATA_W'(tap_addr) ^ DEF_XOR)));

    p_protect_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(attach_req) && $past(wr_en) && $past(addr) != CMD_ADDR
         && !$past(reload_bit) && addr == $past(addr))
        |-> (rd_data == $past(rd_data)));

    p_pwrdn_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(intf_pwrdn) |-> ($past(ack_done) && $past(pwrdn_bit)));

    p_pwrdn_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        intf_pwrdn |=> intf_pwrdn);
endmodule

bind cfgmem_regfile cfgmem_regfile_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEF_XOR(DEF_XOR)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .addr      (addr),
    .rd_data   (rd_data),
    .ack_done  (ack_done),
    .tap_addr  (tap_addr),
    .tap_data  (tap_data),
    .attach_req(attach_req),
    .intf_pwrdn(intf_pwrdn),
    .reload_bit(cmd_q.reload),
    .pwrdn_bit (cmd_q.pwrdn)
);

// File: tb/cfgmem_regfile_test.sv
module cfgmem_regfile_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] addr = '0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       ack_done = 1'b0;
    logic [7:0] tap_addr = '0;
    logic [7:0] tap_data;
    logic       attach_req;
    logic       intf_pwrdn;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    cfgmem_regfile uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wr_data(wr_data), .rd_data(rd_data), .ack_done(ack_done),
        .tap_addr(tap_addr), .tap_data(tap_data),
        .attach_req(attach_req), .intf_pwrdn(intf_pwrdn)
    );

    function automatic logic [7:0] dflt(input logic [7:0] a);
        return a ^ 8'hA5;
    endfunction

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    // One write cycle; inputs change at falling edges.
    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input string tag, input logic [7:0] a, input logic [7:0] exp);
        addr = a;
        #1;
        check(tag, rd_data, exp);
    endtask

    // Vector fields: {req, is_write, addr, data, expected}
    localparam int NV = 13;
    localparam logic [28:0] VEC [NV] = '{
        {4'd2, 1'b1, 8'h00, 8'h11, 8'h00},  // R2 write
        {4'd2, 1'b1, 8'h7F, 8'h22, 8'h00},  // R2 write
        {4'd2, 1'b1, 8'hFE, 8'h33, 8'h00},  // R2 write top stored
        {4'd2, 1'b0, 8'h00, 8'h00, 8'h11},  // R2 read
        {4'd2, 1'b0, 8'h7F, 8'h00, 8'h22},  // R2 read
        {4'd2, 1'b0, 8'hFE, 8'h00, 8'h33},  // R2 read
        {4'd1, 1'b0, 8'h01, 8'h00, 8'hA4},  // R1 untouched default
        {4'd1, 1'b0, 8'h80, 8'h00, 8'h25},  // R1 untouched default
        {4'd3, 1'b0, 8'hFF, 8'h00, 8'h00},  // R3 idle command
        {4'd3, 1'b1, 8'hFF, 8'hF8, 8'h00},  // R3 reserved-only write
        {4'd3, 1'b0, 8'hFF, 8'h00, 8'h00},  // R3 reserved ignored
        {4'd2, 1'b1, 8'h00, 8'h5C, 8'h00},  // R2 overwrite
        {4'd2, 1'b0, 8'h00, 8'h00, 8'h5C}   // R2 read overwrite
    };

    initial begin
        repeat (3) @(negedge clk);
        tap_addr = 8'hFE; #1;
        check("R1 tap during reset", tap_data, 8'h5B);
        rst_n = 1'b1;
        @(negedge clk);
        rd("R1 FFh after reset", 8'hFF, 8'h00);
        rd("R1 00h after reset", 8'h00, 8'hA5);
        check("R1 attach_req", {7'd0, attach_req}, 8'h00);
        check("R1 intf_pwrdn", {7'd0, intf_pwrdn}, 8'h00);

        // Table walk
        for (int i = 0; i < NV; i++) begin
            if (VEC[i][24]) begin
                wr(VEC[i][23:16], VEC[i][15:8]);
            end else begin
                @(negedge clk);
                rd($sformatf("R%0d vector %0d", VEC[i][28:25], i), VEC[i][23:16], VEC[i][7:0]);
            end
        end
        tap_addr = 8'h7F; #1;
        check("R2 tap port", tap_data, 8'h22);

        // R5 protection and R8 command writable while attached
        wr(8'hFF, 8'h01);
        check("R5 attach_req set", {7'd0, attach_req}, 8'h01);
        rd("R5 FFh attach bit", 8'hFF, 8'h01);
        wr(8'h00, 8'h77);
        rd("R5 write dropped", 8'h00, 8'h5C);
        wr(8'hFF, 8'h00);
        check("R8 attach cleared", {7'd0, attach_req}, 8'h00);
        wr(8'h00, 8'h77);
        rd("R5 released", 8'h00, 8'h77);

        // R4 reload
        wr(8'h20, 8'h99);
        rd("R4 pre-reload data", 8'h20, 8'h99);
        wr(8'hFF, 8'h03);
        rd("R4 reload bit visible", 8'hFF, 8'h03);
        addr = 8'h21; wr_data = 8'h44; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        rd("R4 reload bit cleared", 8'hFF, 8'h00);
        rd("R4 20h default", 8'h20, dflt(8'h20));
        rd("R4 write during reload dropped", 8'h21, dflt(8'h21));
        rd("R4 00h default", 8'h00, 8'hA5);
        check("R4 attach cleared", {7'd0, attach_req}, 8'h00);

        // R6 power-down timing
        @(negedge clk); ack_done = 1'b1;
        @(negedge clk); ack_done = 1'b0;
        check("R6 ack without request", {7'd0, intf_pwrdn}, 8'h00);
        @(negedge clk);
        addr = 8'hFF; wr_data = 8'h04; wr_en = 1'b1; ack_done = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; ack_done = 1'b0;
        check("R6 ack in write cycle ignored", {7'd0, intf_pwrdn}, 8'h00);
        rd("R6 bit2 stored", 8'hFF, 8'h04);
        ack_done = 1'b1;
        @(negedge clk);
        ack_done = 1'b0;
        check("R6 powered down", {7'd0, intf_pwrdn}, 8'h01);

        // R7 stickiness
        wr(8'hFF, 8'h00);
        check("R7 survives bit2 clear", {7'd0, intf_pwrdn}, 8'h01);
        wr(8'hFF, 8'h02);
        repeat (2) @(negedge clk);
        check("R7 survives reload", {7'd0, intf_pwrdn}, 8'h01);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check("R7 cleared by rst_n", {7'd0, intf_pwrdn}, 8'h00);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule